// File: doc/BRIEF.md
# Indexed Register Gather and Swizzle Unit

This unit performs two register-to-register permutations over a small internal register array, one element per clock. The indexed move (gather) reads, for each element `i`, an index held in register `rs1+i` and copies register `rs2+index` into register `rd+i`. The swizzle treats a run of registers starting at `rs1` as groups of four. Within each group, every output lane picks its source lane from a 2-bit field of an 8-bit immediate.

An operation starts with a one-cycle `start` while the unit is idle. It first reads and captures every source element, then writes every destination element, and ends with a one-cycle `done`. If an index or a register address is found to be out of range, the operation stops and `trap` is raised together with `done`. A test port lets the array be loaded and inspected while the unit is idle.

Top module: `vperm_unit`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done` and `trap` are low.
- R2: With `op_sel`=0 (gather), for i in 0..VL-1, register `rd+i` receives the value register `rs2+k` held at start, where k is the value register `rs1+i` held at start.
- R3: A gather in which any index k is not less than VL ends with `trap` and leaves the whole array unchanged.
- R4: With `op_sel`=1 (swizzle), the operation covers 4*VL elements. Destination element 4g+j (lane j = 0..3) receives source element 4g+m, where m = `imm_sel[2j+1:2j]`.
- R5: All sources are captured before any destination is written, so overlapping source and destination ranges give the result of a fully parallel copy.
- R6: A source address past the last register (`rs1+i` or `rs2+k` not below 32) ends the operation with `trap` and no register written.
- R7: If `rd+i` is not below 32, elements 0..i-1 stay written, nothing further is written, and `trap` is raised.
- R8: `busy` is high for exactly R+Wr cycles starting the cycle after `start`, where R is the number of read cycles and Wr the number of write cycles. `done` is then high for one cycle with `busy` low, and `trap` is high only together with `done`. A completed operation has R = Wr = element count. On a fault, the faulting element's cycle is the last one counted.
- R9: `start` is ignored while `busy` or `done` is high.
- R10: `tw_en` writes `tw_data` to `tw_addr` at the clock edge only while `busy` is low, and is ignored while `busy` is high. `tr_data` shows register `tr_addr` combinationally.
- R11: A `vlen` of 0 or above 8 gives `done` with `trap` in the cycle after `start`, with no register written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_sel | input | 1 | 0 = gather, 1 = swizzle |
| vlen | input | 4 | Vector length VL, legal 1..8 |
| rd_base | input | 5 | First destination register |
| rs1_base | input | 5 | Index base (gather) or source base (swizzle) |
| rs2_base | input | 5 | Data base for gather |
| imm_sel | input | 8 | Four packed 2-bit lane selectors for swizzle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Fault flag, valid with done |
| tw_en | input | 1 | Test write enable |
| tw_addr | input | 5 | Test write register |
| tw_data | input | 32 | Test write data |
| tr_addr | input | 5 | Test read register |
| tr_data | output | 32 | Test read data |

## Verification
The array has a single write port shared between the unit's write phase and the test port. A test write can therefore land in a cycle where the unit is also writing, and a second `start` can arrive while an operation is in flight. The bench provokes both in the middle of a gather. It aims the test write at a register the operation uses as an index, so that an accepted write would corrupt the later results. The array read back afterwards, and the cycle-by-cycle handshake, are compared against a behavioural model that discards both events.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } vperm_state_e;

  typedef enum logic {
    OP_GATHER  = 1'b0,
    OP_SWIZZLE = 1'b1
  } vperm_op_e;

  localparam int LANES_PER_GROUP = 4;
  localparam int LANE_SEL_W      = 2;

endpackage

// File: rtl/vperm_store.sv
module vperm_store #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  parameter int NRD   = 1,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[raddr[p]];
  end

endmodule

// File: rtl/vperm_src_sel.sv
module vperm_src_sel
  import vperm_pkg::*;
#(
  parameter int CW   = 5,
  parameter int IMMW = 8
) (
  input  vperm_op_e         op,
  input  logic [CW-1:0]     cnt,
  input  logic [IMMW-1:0]   imm,
  output logic [CW-1:0]     sel
);

  localparam int LB = $clog2(LANES_PER_GROUP);

  logic [LANE_SEL_W-1:0] lane_src [LANES_PER_GROUP];

  for (genvar j = 0; j < LANES_PER_GROUP; j++) begin : g_lane
    assign lane_src[j] = imm[LANE_SEL_W*j +: LANE_SEL_W];
  end

  always_comb begin
    if (op == OP_SWIZZLE) begin
      sel = {cnt[CW-1:LB], lane_src[cnt[LB-1:0]]};
    end else begin
      sel = cnt;
    end
  end

endmodule

// File: rtl/vperm_ctrl.sv
module vperm_ctrl
  import vperm_pkg::*;
#(
  parameter int AW     = 5,
  parameter int CW     = 5,
  parameter int VLW    = 4,
  parameter int VL_MAX = 8,
  parameter int IMMW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [AW-1:0]   rd_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [AW-1:0]   rs2_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic            rd_fault,
  input  logic            wr_fault,
  output logic [CW-1:0]   cnt,
  output vperm_op_e       op_q,
  output logic [VLW-1:0]  vl_q,
  output logic [AW-1:0]   rd_q,
  output logic [AW-1:0]   rs1_q,
  output logic [AW-1:0]   rs2_q,
  output logic [IMMW-1:0] imm_q,
  output logic            busy,
  output logic            done,
  output logic            trap,
  output logic            buf_we,
  output logic            arr_we
);

  localparam int LW = CW + 1;

  vperm_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          trap_q, trap_d;
  logic          accept;
  logic          vl_ok;
  logic [LW-1:0] elem_cnt;
  logic [LW-1:0] last_idx;
  logic          is_last;

  assign accept = (state_q == ST_IDLE) && start;
  assign vl_ok  = (vl_i != '0) && ({1'b0, vl_i} <= (VLW+1)'(VL_MAX));

  assign elem_cnt = (op_q == OP_SWIZZLE) ? (LW'(vl_q) << 2) : LW'(vl_q);
  assign last_idx = elem_cnt - LW'(1);
  assign is_last  = ({1'b0, cnt_q} == last_idx);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    trap_d  = trap_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cnt_d = '0;
          if (vl_ok) begin
            state_d = ST_READ;
            trap_d  = 1'b0;
          end else begin
            state_d = ST_FIN;
            trap_d  = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (rd_fault) begin
          state_d = ST_FIN;
          trap_d  = 1'b1;
        end else if (is_last) begin
          state_d = ST_WRITE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_WRITE: begin
        if (wr_fault) begin
          state_d = ST_FIN;
          trap_d  = 1'b1;
        end else if (is_last) begin
          state_d = ST_FIN;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      trap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      trap_q  <= trap_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q  <= vperm_op_e'(op_i);
      vl_q  <= vl_i;
      rd_q  <= rd_i;
      rs1_q <= rs1_i;
      rs2_q <= rs2_i;
      imm_q <= imm_i;
    end
  end

  assign cnt    = cnt_q;
  assign busy   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign done   = (state_q == ST_FIN);
  assign trap   = (state_q == ST_FIN) && trap_q;
  assign buf_we = (state_q == ST_READ) && !rd_fault;
  assign arr_we = (state_q == ST_WRITE) && !wr_fault;

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int W      = 32,
  parameter int VL_MAX = 8,
  parameter int VLW    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    op_sel,
  input  logic [VLW-1:0]          vlen,
  input  logic [$clog2(NREG)-1:0] rd_base,
  input  logic [$clog2(NREG)-1:0] rs1_base,
  input  logic [$clog2(NREG)-1:0] rs2_base,
  input  logic [7:0]              imm_sel,
  output logic                    busy,
  output logic                    done,
  output logic                    trap,
  input  logic                    tw_en,
  input  logic [$clog2(NREG)-1:0] tw_addr,
  input  logic [W-1:0]            tw_data,
  input  logic [$clog2(NREG)-1:0] tr_addr,
  output logic [W-1:0]            tr_data
);

  localparam int AW    = $clog2(NREG);
  localparam int ELEMS = LANES_PER_GROUP * VL_MAX;
  localparam int CW    = $clog2(ELEMS);
  localparam int SW    = ((AW > CW) ? AW : CW) + 1;
  localparam int IMMW  = 8;

  logic [CW-1:0]   cnt;
  vperm_op_e       op_q;
  logic [VLW-1:0]  vl_q;
  logic [AW-1:0]   rd_q, rs1_q, rs2_q;
  logic [IMMW-1:0] imm_q;
  logic            rd_fault, wr_fault;
  logic            buf_we, unit_we;

  logic [SW-1:0]   src_sum, dat_sum, dst_sum;
  logic [W-1:0]    idx_val;
  logic            idx_ok;

  logic [2:0][AW-1:0] rf_raddr;
  logic [2:0][W-1:0]  rf_rdata;
  logic               rf_we;
  logic [AW-1:0]      rf_waddr;
  logic [W-1:0]       rf_wdata;
  logic               tw_ok;

  logic [CW-1:0]      snap_sel;
  logic [0:0][CW-1:0] snap_raddr;
  logic [0:0][W-1:0]  snap_rdata;
  logic [W-1:0]       snap_wdata;

  vperm_ctrl #(
    .AW(AW), .CW(CW), .VLW(VLW), .VL_MAX(VL_MAX), .IMMW(IMMW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_i    (op_sel),
    .vl_i    (vlen),
    .rd_i    (rd_base),
    .rs1_i   (rs1_base),
    .rs2_i   (rs2_base),
    .imm_i   (imm_sel),
    .rd_fault(rd_fault),
    .wr_fault(wr_fault),
    .cnt     (cnt),
    .op_q    (op_q),
    .vl_q    (vl_q),
    .rd_q    (rd_q),
    .rs1_q   (rs1_q),
    .rs2_q   (rs2_q),
    .imm_q   (imm_q),
    .busy    (busy),
    .done    (done),
    .trap    (trap),
    .buf_we  (buf_we),
    .arr_we  (unit_we)
  );

  // read-phase address generation and range checks
  assign src_sum = SW'(rs1_q) + SW'(cnt);
  assign idx_val = rf_rdata[0];
  assign idx_ok  = idx_val < W'(vl_q);
  assign dat_sum = SW'(rs2_q) + SW'(idx_val[CW-1:0]);

  assign rd_fault = (src_sum >= SW'(NREG)) ||
                    ((op_q == OP_GATHER) && (!idx_ok || (dat_sum >= SW'(NREG))));

  // write-phase address generation and range check
  assign dst_sum  = SW'(rd_q) + SW'(cnt);
  assign wr_fault = dst_sum >= SW'(NREG);

  // register array: port 0 index/source, port 1 gather data, port 2 test
  assign rf_raddr[0] = src_sum[AW-1:0];
  assign rf_raddr[1] = dat_sum[AW-1:0];
  assign rf_raddr[2] = tr_addr;

  assign tw_ok    = tw_en && !busy;
  assign rf_we    = unit_we || tw_ok;
  assign rf_waddr = unit_we ? dst_sum[AW-1:0] : tw_addr;
  assign rf_wdata = unit_we ? snap_rdata[0] : tw_data;

  vperm_store #(.DEPTH(NREG), .W(W), .NRD(3)) u_regs (
    .clk  (clk),
    .we   (rf_we),
    .waddr(rf_waddr),
    .wdata(rf_wdata),
    .raddr(rf_raddr),
    .rdata(rf_rdata)
  );

  assign tr_data = rf_rdata[2];

  // snapshot of all source elements, filled before any write
  assign snap_wdata = (op_q == OP_GATHER) ? rf_rdata[1] : rf_rdata[0];

  vperm_src_sel #(.CW(CW), .IMMW(IMMW)) u_sel (
    .op (op_q),
    .cnt(cnt),
    .imm(imm_q),
    .sel(snap_sel)
  );

  assign snap_raddr[0] = snap_sel;

  vperm_store #(.DEPTH(ELEMS), .W(W), .NRD(1)) u_snap (
    .clk  (clk),
    .we   (buf_we),
    .waddr(cnt),
    .wdata(snap_wdata),
    .raddr(snap_raddr),
    .rdata(snap_rdata)
  );

endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic trap,
  input logic unit_we
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy || start)); // R11

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R9

  AST_WRITE_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    unit_we |=> (busy || done)); // R10

endmodule

bind vperm_unit vperm_unit_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .trap   (trap),
  .unit_we(unit_we)
);

// File: tb/sim_vperm_unit.sv
module sim_vperm_unit;

  localparam int NREG = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start, op_sel;
  logic [3:0]  vlen;
  logic [4:0]  rd_base, rs1_base, rs2_base;
  logic [7:0]  imm_sel;
  logic        busy, done, trap;
  logic        tw_en;
  logic [4:0]  tw_addr, tr_addr;
  logic [31:0] tw_data, tr_data;

  always #5 clk = ~clk;

  vperm_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .vlen(vlen),
    .rd_base(rd_base), .rs1_base(rs1_base), .rs2_base(rs2_base), .imm_sel(imm_sel),
    .busy(busy), .done(done), .trap(trap),
    .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
    .tr_addr(tr_addr), .tr_data(tr_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 0;

  // behavioural reference
  int unsigned mm [NREG];
  int          m_phase;   // 0 idle, 1 working, 2 done
  int          m_left;
  bit          m_trap;

  task automatic model_exec(output int len, output bit tr);
    int unsigned snap [32];
    int n, nrd, nwr;
    int unsigned k;
    tr = 0; nrd = 0; nwr = 0;
    if (vlen == 0 || vlen > 8) begin
      len = 0; tr = 1; return;
    end
    n = op_sel ? 4 * int'(vlen) : int'(vlen);
    for (int i = 0; i < n; i++) begin
      nrd = i + 1;
      if (int'(rs1_base) + i >= NREG) begin tr = 1; break; end
      if (!op_sel) begin
        k = mm[int'(rs1_base) + i];
        if (k >= vlen) begin tr = 1; break; end
        if (int'(rs2_base) + int'(k) >= NREG) begin tr = 1; break; end
        snap[i] = mm[int'(rs2_base) + int'(k)];
      end else begin
        snap[i] = mm[int'(rs1_base) + i];
      end
    end
    if (!tr) begin
      for (int i = 0; i < n; i++) begin
        nwr = i + 1;
        if (int'(rd_base) + i >= NREG) begin tr = 1; break; end
        if (op_sel)
          mm[int'(rd_base) + i] = snap[(i / 4) * 4 + ((int'(imm_sel) >> (2 * (i % 4))) & 3)];
        else
          mm[int'(rd_base) + i] = snap[i];
      end
    end
    len = nrd + nwr;
  endtask

  always @(posedge clk) begin
    int len;
    bit tr;
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_trap = 0;
    end else begin
      case (m_phase)
        0: begin
          if (tw_en) mm[tw_addr] = tw_data;
          if (start) begin
            model_exec(len, tr);
            m_trap = tr;
            if (len == 0) m_phase = 2;
            else begin m_phase = 1; m_left = len; end
          end
        end
        1: begin
          m_left = m_left - 1;
          if (m_left == 0) m_phase = 2;
        end
        default: begin
          if (tw_en) mm[tw_addr] = tw_data;
          m_phase = 0;
        end
      endcase
    end
  end

  // per-clock handshake comparison (R8, R9)
  always @(negedge clk) begin
    bit eb, ed, et;
    if (chk_on) begin
      eb = (m_phase == 1);
      ed = (m_phase == 2);
      et = (m_phase == 2) && m_trap;
      n_cmp++;
      if (busy !== eb || done !== ed || trap !== et) begin
        n_bad++;
        $display("FAIL R8 handshake at %0t: busy/done/trap=%b%b%b expected %b%b%b",
                 $time, busy, done, trap, eb, ed, et);
      end
    end
  end

  task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(int a, int unsigned v);
    tw_en = 1'b1; tw_addr = 5'(a); tw_data = v;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic check_array(string tag);
    for (int k = 0; k < NREG; k++) begin
      tr_addr = 5'(k);
      #1;
      check1(tag, tr_data, mm[k]);
    end
  endtask

  task automatic run_op(string tag, bit op, int vl, int rd, int rs1, int rs2,
                        int imm, bit exp_trap, bit disturb);
    bit seen_trap;
    op_sel = op; vlen = 4'(vl); rd_base = 5'(rd); rs1_base = 5'(rs1);
    rs2_base = 5'(rs2); imm_sel = 8'(imm); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      @(negedge clk);
      // second start and a test write while the gather runs (R9, R10)
      start = 1'b1; op_sel = 1'b1; vlen = 4'd1; rd_base = 5'd0; rs1_base = 5'd20;
      tw_en = 1'b1; tw_addr = 5'd2; tw_data = 32'h0000_0001;
      @(negedge clk);
      start = 1'b0; tw_en = 1'b0;
    end
    while (!done) @(negedge clk);
    seen_trap = trap;
    check1({tag, " trap flag"}, 32'(seen_trap), 32'(exp_trap));
    @(negedge clk);
    check_array(tag);
  endtask

  initial begin
    start = 0; op_sel = 0; vlen = 0; rd_base = 0; rs1_base = 0; rs2_base = 0;
    imm_sel = 0; tw_en = 0; tw_addr = 0; tw_data = 0; tr_addr = 0;
    repeat (3) @(negedge clk);
    check1("R1 busy in reset", 32'(busy), 0);
    check1("R1 done in reset", 32'(done), 0);
    check1("R1 trap in reset", 32'(trap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_on = 1;
    check1("R1 after release", {29'd0, busy, done, trap}, 0);

    // load the array through the test port (R10)
    for (int k = 0; k < NREG; k++) begin
      if (k < 16) poke(k, (k * 5 + 3) % 8);
      else        poke(k, 32'hA000_0000 + k * 32'h111);
    end
    check_array("R10 test load");

    run_op("R2 gather basic",        0, 8, 24, 0, 16, 0,    0, 0);
    run_op("R3 index not below VL",  0, 4, 24, 0, 16, 0,    1, 0);
    run_op("R4 swizzle reverse",     1, 2,  8, 16, 0, 8'h1B, 0, 0);
    run_op("R4 swizzle broadcast",   1, 1, 12, 20, 0, 8'h00, 0, 0);
    run_op("R5 swizzle in place",    1, 2, 16, 16, 0, 8'h1B, 0, 0);
    run_op("R5 gather overlap",      0, 8, 17, 0, 16, 0,    0, 0);
    run_op("R6 source past end",     1, 2,  0, 28, 0, 8'hE4, 1, 0);
    run_op("R6 data past end",       0, 8,  8, 0, 30, 0,    1, 0);
    run_op("R7 dest past end",       0, 8, 28, 0, 16, 0,    1, 0);
    run_op("R9 R10 collision",       0, 8,  8, 0, 16, 0,    0, 1);
    run_op("R11 vl zero",            0, 0,  0, 0, 16, 0,    1, 0);
    run_op("R11 vl above max",       1, 9,  0, 0, 16, 0,    1, 0);
    run_op("R4 swizzle full length", 1, 8,  0, 0, 0, 8'h4E, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule